// File: doc/BRIEF.md
# Segmented Address Generator

This block turns one memory or port reference into the address that goes out on the bus. For each request it receives a reference kind, an addressing-mode description, a displacement, the current pointer and index register values, the four segment register values and an optional segment override. It forms a 16-bit effective offset from any mix of one base register, one index register and a short or full displacement. It then picks the segment that the reference uses and returns the segment code, the offset and the 20-bit physical address. The physical address is the segment value shifted left by four bits plus the offset.

Instruction fetch, stack-pointer references and string destinations each use a fixed segment and offset register. Port references produce a 16-bit port number instead of a memory address. Results are registered and appear one clock after the request. Decoding instructions and holding register contents are left to the surrounding core.

Top module: `eaddr_gen`

## Requirements
- R1: A request with `req_valid` high gives `out_valid` high on the next clock, and `out_valid` is low in the cycle after a clock with no request. For a memory reference, `out_phys` equals (segment value × 16 + `out_offset`) modulo 2^20.
- R2: For a data reference (`req_kind` 0, or any kind code above 5), `out_offset` is the sum modulo 2^16 of the base term, the index term and the displacement term. Base codes: 0 none, 1 BX, 2 BP, 3 none. Index codes: 0 none, 1 SI, 2 DI, 3 none. Displacement codes: 0 none, 1 short, 2 full 16-bit, 3 none. All nine base and index pairs work with every displacement code.
- R3: A short displacement is `req_disp[7:0]` sign-extended to 16 bits, and `req_disp[15:8]` has no effect on it.
- R4: When no override is given, a data reference whose base code is BP uses SS. Any other data reference uses DS, including index-only and displacement-only forms. Segment codes: ES 0, CS 1, SS 2, DS 3.
- R5: An instruction fetch (`req_kind` 1) uses CS with offset IP, whatever the override inputs are.
- R6: A stack reference (`req_kind` 2) uses SS with offset SP, whatever the override inputs are.
- R7: A string destination (`req_kind` 3) uses ES with offset DI, whatever the override inputs are.
- R8: For a data reference with `ovr_valid` high, `out_seg` equals `ovr_seg`, and that segment's value forms the physical address.
- R9: A short port reference (`req_kind` 4) gives `out_io` high and port `{8'h00, req_disp[7:0]}`, which covers 0000h to 00FFh. `out_offset` carries the port, `out_phys` is the port zero-extended to 20 bits, and `out_seg` is 0.
- R10: A wide port reference (`req_kind` 5) gives `out_io` high with port DX, presented the same way as in R9.
- R11: While `rst_n` is low, `out_valid`, `out_io`, `out_seg`, `out_offset` and `out_phys` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 data, 1 fetch, 2 stack, 3 string destination, 4 short port, 5 wide port |
| req_base | input | 2 | Base register code |
| req_index | input | 2 | Index register code |
| req_disp_sz | input | 2 | Displacement code |
| req_disp | input | OFS_W | Displacement, or short port number in the low byte |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| reg_bx | input | OFS_W | BX value |
| reg_bp | input | OFS_W | BP value |
| reg_si | input | OFS_W | SI value |
| reg_di | input | OFS_W | DI value |
| reg_sp | input | OFS_W | SP value |
| reg_ip | input | OFS_W | IP value |
| reg_dx | input | OFS_W | DX value (wide port number) |
| seg_es | input | OFS_W | ES value |
| seg_cs | input | OFS_W | CS value |
| seg_ss | input | OFS_W | SS value |
| seg_ds | input | OFS_W | DS value |
| out_valid | output | 1 | Result valid |
| out_io | output | 1 | Result is a port number |
| out_seg | output | 2 | Segment code used |
| out_offset | output | OFS_W | Effective offset or port number |
| out_phys | output | OFS_W+SEG_SHIFT | Physical address |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a four-bit segment shift and an 8-bit short displacement. This is the 20-bit address space. With these values, a DS of FFFFh makes any offset of 0010h or more wrap past 2^20, and base, index and displacement values near FFFFh make the offset wrap past 2^16. A displacement byte of 80h reaches the negative end of the sign extension. Using distinct values in all four segment registers shows every wrong segment choice as a wrong physical address.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

  typedef enum logic [2:0] {
    K_DATA     = 3'd0,
    K_FETCH    = 3'd1,
    K_STACK    = 3'd2,
    K_STRDST   = 3'd3,
    K_IO_SHORT = 3'd4,
    K_IO_WIDE  = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_BX   = 2'd1,
    BASE_BP   = 2'd2
  } base_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_SI   = 2'd1,
    IDX_DI   = 2'd2
  } idx_e;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_SHORT = 2'd1,
    DISP_FULL  = 2'd2
  } disp_e;

endpackage

// File: rtl/eaddr_offset.sv
module eaddr_offset
  import eaddr_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]       kind,
  input  logic [1:0]       base_code,
  input  logic [1:0]       idx_code,
  input  logic [1:0]       disp_code,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  input  logic [OFS_W-1:0] sp,
  input  logic [OFS_W-1:0] ip,
  input  logic [OFS_W-1:0] dx,
  output logic [OFS_W-1:0] offset,
  output logic             is_io
);

  localparam int EXT_W = OFS_W - SHORT_W;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] idx_term;
  logic [OFS_W-1:0] disp_term;
  logic [OFS_W-1:0] short_sext;
  logic [OFS_W-1:0] short_port;
  logic [OFS_W-1:0] ea_sum;

  // Short displacement is widened with its top bit copied upwards.
  assign short_sext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign short_port = {{EXT_W{1'b0}}, disp[SHORT_W-1:0]};

  always_comb begin
    base_term = '0;
    case (base_code)
      BASE_BX: base_term = bx;
      BASE_BP: base_term = bp;
      default: base_term = '0;
    endcase

    idx_term = '0;
    case (idx_code)
      IDX_SI:  idx_term = si;
      IDX_DI:  idx_term = di;
      default: idx_term = '0;
    endcase

    disp_term = '0;
    case (disp_code)
      DISP_SHORT: disp_term = short_sext;
      DISP_FULL:  disp_term = disp;
      default:    disp_term = '0;
    endcase
  end

  // Sum truncates to OFS_W bits, giving modulo 2^OFS_W wrap.
  assign ea_sum = base_term + idx_term + disp_term;

  always_comb begin
    offset = ea_sum;
    is_io  = 1'b0;
    case (kind)
      K_FETCH:    offset = ip;
      K_STACK:    offset = sp;
      K_STRDST:   offset = di;
      K_IO_SHORT: begin
        offset = short_port;
        is_io  = 1'b1;
      end
      K_IO_WIDE:  begin
        offset = dx;
        is_io  = 1'b1;
      end
      default:    offset = ea_sum;
    endcase
  end

endmodule

// File: rtl/eaddr_segsel.sv
module eaddr_segsel
  import eaddr_pkg::*;
(
  input  logic [2:0] kind,
  input  logic [1:0] base_code,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output logic [1:0] seg_code
);

  logic [1:0] data_default;

  assign data_default = (base_code == BASE_BP) ? SEG_SS : SEG_DS;

  always_comb begin
    case (kind)
      K_FETCH:    seg_code = SEG_CS;
      K_STACK:    seg_code = SEG_SS;
      K_STRDST:   seg_code = SEG_ES;
      K_IO_SHORT: seg_code = 2'd0;
      K_IO_WIDE:  seg_code = 2'd0;
      default:    seg_code = ovr_valid ? ovr_seg : data_default;
    endcase
  end

endmodule

// File: rtl/eaddr_phys.sv
module eaddr_phys
  import eaddr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic [1:0]       seg_code,
  input  logic             is_io,
  input  logic [OFS_W-1:0] offset,
  input  logic [OFS_W-1:0] es,
  input  logic [OFS_W-1:0] cs,
  input  logic [OFS_W-1:0] ss,
  input  logic [OFS_W-1:0] ds,
  output logic [PA_W-1:0]  phys
);

  logic [OFS_W-1:0] seg_val;
  logic [PA_W-1:0]  seg_base;
  logic [PA_W-1:0]  ofs_ext;

  always_comb begin
    case (seg_code)
      SEG_ES:  seg_val = es;
      SEG_CS:  seg_val = cs;
      SEG_SS:  seg_val = ss;
      default: seg_val = ds;
    endcase
  end

  assign seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
  assign ofs_ext  = {{SEG_SHIFT{1'b0}}, offset};
  // Sum truncates to PA_W bits, giving modulo 2^PA_W wrap.
  assign phys     = is_io ? ofs_ext : (seg_base + ofs_ext);

endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eaddr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [1:0]       req_base,
  input  logic [1:0]       req_index,
  input  logic [1:0]       req_disp_sz,
  input  logic [OFS_W-1:0] req_disp,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] reg_sp,
  input  logic [OFS_W-1:0] reg_ip,
  input  logic [OFS_W-1:0] reg_dx,
  input  logic [OFS_W-1:0] seg_es,
  input  logic [OFS_W-1:0] seg_cs,
  input  logic [OFS_W-1:0] seg_ss,
  input  logic [OFS_W-1:0] seg_ds,
  output logic             out_valid,
  output logic             out_io,
  output logic [1:0]       out_seg,
  output logic [OFS_W-1:0] out_offset,
  output logic [PA_W-1:0]  out_phys
);

  logic [OFS_W-1:0] nxt_offset;
  logic             nxt_io;
  logic [1:0]       nxt_seg;
  logic [PA_W-1:0]  nxt_phys;

  logic             valid_q;
  logic             io_q;
  logic [1:0]       seg_q;
  logic [OFS_W-1:0] offset_q;
  logic [PA_W-1:0]  phys_q;

  eaddr_offset #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_offset (
    .kind      (req_kind),
    .base_code (req_base),
    .idx_code  (req_index),
    .disp_code (req_disp_sz),
    .disp      (req_disp),
    .bx        (reg_bx),
    .bp        (reg_bp),
    .si        (reg_si),
    .di        (reg_di),
    .sp        (reg_sp),
    .ip        (reg_ip),
    .dx        (reg_dx),
    .offset    (nxt_offset),
    .is_io     (nxt_io)
  );

  eaddr_segsel u_segsel (
    .kind      (req_kind),
    .base_code (req_base),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg_code  (nxt_seg)
  );

  eaddr_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_code (nxt_seg),
    .is_io    (nxt_io),
    .offset   (nxt_offset),
    .es       (seg_es),
    .cs       (seg_cs),
    .ss       (seg_ss),
    .ds       (seg_ds),
    .phys     (nxt_phys)
  );

  // Result register: valid every cycle, payload on request only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      io_q     <= 1'b0;
      seg_q    <= '0;
      offset_q <= '0;
      phys_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        io_q     <= nxt_io;
        seg_q    <= nxt_seg;
        offset_q <= nxt_offset;
        phys_q   <= nxt_phys;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_io     = io_q;
  assign out_seg    = seg_q;
  assign out_offset = offset_q;
  assign out_phys   = phys_q;

endmodule

// File: rtl/eaddr_gen_chk.sv
module eaddr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [1:0]       req_base,
  input logic             ovr_valid,
  input logic [1:0]       ovr_seg,
  input logic [OFS_W-1:0] reg_di,
  input logic [OFS_W-1:0] reg_ip,
  input logic [OFS_W-1:0] seg_es,
  input logic [OFS_W-1:0] seg_cs,
  input logic [OFS_W-1:0] seg_ss,
  input logic [OFS_W-1:0] seg_ds,
  input logic             out_valid,
  input logic             out_io,
  input logic [1:0]       out_seg,
  input logic [OFS_W-1:0] out_offset,
  input logic [PA_W-1:0]  out_phys
);

  logic [OFS_W-1:0] es_q, cs_q, ss_q, ds_q;
  logic [OFS_W-1:0] used_seg;
  logic [PA_W-1:0]  expect_phys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q <= '0;
      cs_q <= '0;
      ss_q <= '0;
      ds_q <= '0;
    end else begin
      es_q <= seg_es;
      cs_q <= seg_cs;
      ss_q <= seg_ss;
      ds_q <= seg_ds;
    end
  end

  always_comb begin
    case (out_seg)
      2'd0:    used_seg = es_q;
      2'd1:    used_seg = cs_q;
      2'd2:    used_seg = ss_q;
      default: used_seg = ds_q;
    endcase
    expect_phys = {used_seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, out_offset};
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  p_phys_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_io) |-> (out_phys == expect_phys));

  p_bp_default_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && !ovr_valid && req_base == 2'd2) |=> (out_seg == 2'd2));

  p_fetch_cs_ip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1) |=> (out_seg == 2'd1 && out_offset == $past(reg_ip)));

  p_strdst_es_di_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3) |=> (out_seg == 2'd0 && out_offset == $past(reg_di)));

  p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && ovr_valid) |=> (out_seg == $past(ovr_seg)));

  p_port_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_io) |-> (out_phys[PA_W-1:OFS_W] == '0 && out_seg == 2'd0));

endmodule

bind eaddr_gen eaddr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_base   (req_base),
  .ovr_valid  (ovr_valid),
  .ovr_seg    (ovr_seg),
  .reg_di     (reg_di),
  .reg_ip     (reg_ip),
  .seg_es     (seg_es),
  .seg_cs     (seg_cs),
  .seg_ss     (seg_ss),
  .seg_ds     (seg_ds),
  .out_valid  (out_valid),
  .out_io     (out_io),
  .out_seg    (out_seg),
  .out_offset (out_offset),
  .out_phys   (out_phys)
);

// File: tb/tb_eaddr_gen.sv
module tb_eaddr_gen;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    logic        io;
    logic [1:0]  seg;
    logic [15:0] off;
    logic [19:0] phys;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [1:0]  req_base, req_index, req_disp_sz;
  logic [15:0] req_disp;
  logic        ovr_valid;
  logic [1:0]  ovr_seg;
  logic [15:0] reg_bx = 16'h1234, reg_bp = 16'hF000, reg_si = 16'h0F00, reg_di = 16'h8001;
  logic [15:0] reg_sp = 16'hFFFE, reg_ip = 16'h0100, reg_dx = 16'hBEEF;
  logic [15:0] seg_es = 16'hA000, seg_cs = 16'hF000, seg_ss = 16'h3000, seg_ds = 16'hFFFF;
  logic        out_valid, out_io;
  logic [1:0]  out_seg;
  logic [15:0] out_offset;
  logic [19:0] out_phys;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eaddr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_base(req_base), .req_index(req_index), .req_disp_sz(req_disp_sz),
    .req_disp(req_disp), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .reg_sp(reg_sp), .reg_ip(reg_ip), .reg_dx(reg_dx),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .out_io(out_io), .out_seg(out_seg),
    .out_offset(out_offset), .out_phys(out_phys)
  );

  function automatic logic [15:0] seg_value(input logic [1:0] code);
    case (code)
      2'd0:    return seg_es;
      2'd1:    return seg_cs;
      2'd2:    return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  // Expected result written from the requirements.
  function automatic exp_t model(input string tag, input logic [2:0] kind,
      input logic [1:0] b, input logic [1:0] x, input logic [1:0] d,
      input logic [15:0] disp, input logic ov, input logic [1:0] os);
    exp_t e;
    logic [15:0] bt, xt, dt;
    e.tag = tag;
    e.io  = 1'b0;
    case (kind)
      3'd1: begin e.seg = 2'd1; e.off = reg_ip; end
      3'd2: begin e.seg = 2'd2; e.off = reg_sp; end
      3'd3: begin e.seg = 2'd0; e.off = reg_di; end
      3'd4: begin e.seg = 2'd0; e.off = {8'h00, disp[7:0]}; e.io = 1'b1; end
      3'd5: begin e.seg = 2'd0; e.off = reg_dx; e.io = 1'b1; end
      default: begin
        bt = (b == 2'd1) ? reg_bx : (b == 2'd2) ? reg_bp : 16'h0000;
        xt = (x == 2'd1) ? reg_si : (x == 2'd2) ? reg_di : 16'h0000;
        dt = (d == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : (d == 2'd2) ? disp : 16'h0000;
        e.off = bt + xt + dt;
        e.seg = ov ? os : ((b == 2'd2) ? 2'd2 : 2'd3);
      end
    endcase
    if (e.io) e.phys = {4'h0, e.off};
    else      e.phys = {seg_value(e.seg), 4'h0} + {4'h0, e.off};
    return e;
  endfunction

  task automatic drive(input string tag, input logic [2:0] kind,
      input logic [1:0] b, input logic [1:0] x, input logic [1:0] d,
      input logic [15:0] disp, input logic ov, input logic [1:0] os);
    @(negedge clk);
    req_valid   = 1'b1;
    req_kind    = kind;
    req_base    = b;
    req_index   = x;
    req_disp_sz = d;
    req_disp    = disp;
    ovr_valid   = ov;
    ovr_seg     = os;
    q.push_back(model(tag, kind, b, x, d, disp, ov, os));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each result with the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        n_run++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R1: result without request, actual valid=%0b expected valid=0", out_valid);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_io !== e.io || out_seg !== e.seg || out_offset !== e.off || out_phys !== e.phys) begin
            n_fail++;
            $display("FAIL %s: actual io=%0b seg=%0d off=%h phys=%h expected io=%0b seg=%0d off=%h phys=%h",
                     e.tag, out_io, out_seg, out_offset, out_phys, e.io, e.seg, e.off, e.phys);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run not finished, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = '0; req_base = '0; req_index = '0;
    req_disp_sz = '0; req_disp = '0; ovr_valid = 1'b0; ovr_seg = '0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;  // R11 reset state
    if (out_valid !== 1'b0 || out_io !== 1'b0 || out_seg !== 2'd0 || out_offset !== 16'h0 || out_phys !== 20'h0) begin
      n_fail++;
      $display("FAIL R11: actual valid=%0b off=%h phys=%h expected all zero", out_valid, out_offset, out_phys);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: every base/index pair with every displacement code.
    for (int b = 0; b < 3; b++)
      for (int x = 0; x < 3; x++)
        for (int d = 0; d < 3; d++)
          drive("R2", 3'd0, 2'(b), 2'(x), 2'(d), 16'h12F0, 1'b0, 2'd0);
    drive("R2", 3'd6, 2'd1, 2'd3, 2'd3, 16'h5555, 1'b0, 2'd0);  // codes 3 mean none
    // R3: sign extension, upper byte ignored.
    drive("R3", 3'd0, 2'd1, 2'd0, 2'd1, 16'hAB80, 1'b0, 2'd0);
    drive("R3", 3'd0, 2'd1, 2'd0, 2'd1, 16'h007F, 1'b0, 2'd0);
    drive("R3", 3'd0, 2'd0, 2'd1, 2'd1, 16'hFFFF, 1'b0, 2'd0);
    // R4: default segments.
    drive("R4", 3'd0, 2'd2, 2'd1, 2'd0, 16'h0000, 1'b0, 2'd0);
    drive("R4", 3'd0, 2'd0, 2'd2, 2'd0, 16'h0000, 1'b0, 2'd0);
    drive("R4", 3'd0, 2'd0, 2'd0, 2'd2, 16'h0004, 1'b0, 2'd0);
    // R1: physical wrap past 2^20 with DS=FFFF.
    drive("R1", 3'd0, 2'd0, 2'd0, 2'd2, 16'h0010, 1'b0, 2'd0);
    drive("R1", 3'd0, 2'd0, 2'd0, 2'd2, 16'hFFFF, 1'b0, 2'd0);
    // R8: override with each code.
    for (int s = 0; s < 4; s++)
      drive("R8", 3'd0, 2'd2, 2'd2, 2'd1, 16'h0033, 1'b1, 2'(s));
    // R5, R6, R7: fixed segments, override ignored.
    drive("R5", 3'd1, 2'd1, 2'd1, 2'd2, 16'h7777, 1'b1, 2'd3);
    drive("R6", 3'd2, 2'd2, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0);
    drive("R7", 3'd3, 2'd1, 2'd1, 2'd2, 16'h1111, 1'b1, 2'd3);
    // R9, R10: port references.
    drive("R9", 3'd4, 2'd1, 2'd1, 2'd1, 16'hAB7F, 1'b1, 2'd3);
    drive("R9", 3'd4, 2'd0, 2'd0, 2'd0, 16'h00FF, 1'b0, 2'd0);
    drive("R10", 3'd5, 2'd2, 2'd2, 2'd2, 16'h0001, 1'b1, 2'd2);
    // Gaps between requests (R1 idle behaviour).
    idle();
    drive("R1", 3'd0, 2'd1, 2'd2, 2'd0, 16'h0000, 1'b0, 2'd0);
    idle();
    idle();
    drive("R2", 3'd0, 2'd2, 2'd2, 2'd2, 16'hFFFF, 1'b0, 2'd0);
    idle();
    repeat (4) @(negedge clk);

    n_run++;  // R1: every request produced exactly one result
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: actual %0d results missing, expected 0", q.size());
    end
    n_run++;  // R1: valid low when idle
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual idle valid=%0b expected 0", out_valid);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule